// File: doc/BRIEF.md
# Receive Frame Checksum Accumulator

This block watches a received Ethernet frame on a wide streaming input and adds up its payload as 16-bit ones'-complement words. The input has data, a per-byte keep mask, a valid flag and an end-of-frame flag, and it has no backpressure. The 14 header bytes at the start of each frame are left out of the sum. Word pairing starts at the first byte after the header, and the result is the folded sum, not its complement. A downstream protocol stage can use this value to validate or finish a transport checksum without reading the payload again.

A full beat of up to 32 bytes is absorbed in one clock cycle. The header boundary may fall anywhere inside a beat, or span beats. Frames may follow each other with no idle cycle, and a frame may pause for any number of cycles. One result and a single-cycle strobe come out for each frame.

Top module: `rx_payload_csum`

## Requirements
- R1: After synchronous active-high reset `rst`, `csum_vld_o` is 0 and `csum_o` is 0x0000. A frame that was cut short by the reset leaves no trace in the next frame's result.
- R2: The first 14 kept bytes of each frame add nothing to the sum. A frame of exactly 14 bytes yields 0x0000.
- R3: Summed bytes are paired in arrival order from the first byte after the header. The byte at an even summed position (0, 2, 4, ...) is the upper byte `[15:8]` of its word, and the next byte is the lower byte `[7:0]`.
- R4: When a frame has an odd number of summed bytes, its final byte is an upper byte whose lower byte is zero.
- R5: Carries out of bit 15 are added back in (end-around carry) until the value fits in 16 bits, and the result is not inverted. A 10240-byte frame of all-0xFF bytes yields 0xFFFF.
- R6: Exactly one `csum_vld_o` pulse, one cycle long, follows each beat that has `s_valid_i` and `s_last_i` both high. It appears in the next cycle, and `csum_o` holds that frame's sum in the same cycle.
- R7: Frames sent with no idle cycle between them each give their own correct sum, in arrival order.
- R8: Cycles with `s_valid_i` low do not change the running sum or the byte position.
- R9: A byte whose `s_keep_i` bit is 0 adds nothing and does not advance the byte position, even when it sits between kept bytes. Keep bit i qualifies data bits `[8*i+7:8*i]`, and lane 0 is the earliest byte.
- R10: Frames that end partway through a beat, including lengths of 1 to 127 summed bytes and jumbo lengths above 9000 bytes, give the correct sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_data_i | input | 256 | Beat data, lane 0 in bits [7:0] is the earliest byte |
| s_keep_i | input | 32 | One qualifier bit per data byte |
| s_valid_i | input | 1 | Beat present this cycle |
| s_last_i | input | 1 | Beat is the end of its frame |
| csum_o | output | 16 | Folded ones'-complement payload sum |
| csum_vld_o | output | 1 | One-cycle strobe marking a new `csum_o` |

## Verification
The assertions take for granted that `s_valid_i` and `s_last_i` are low while reset is applied. They also assume that a frame ends only on a valid beat. The bounded-position and idle-hold properties therefore only describe cycles in which a beat is either fully present or absent. The stimulus keeps to this: it drives every input at the falling edge, forces valid low around reset, and raises the end flag only on the beat that holds the frame's final kept byte, whether the keep mask has holes or not.

// File: rtl/csum_pkg.sv
package csum_pkg;

    localparam int DFLT_DATA_W    = 256;
    localparam int DFLT_HDR_BYTES = 14;
    localparam int WORD_W         = 16;

    // Ones'-complement fold of a wide partial sum into 16 bits.
    function automatic logic [WORD_W-1:0] fold32(input logic [31:0] x);
        logic [16:0] t;
        logic [16:0] u;
        t = {1'b0, x[15:0]} + {1'b0, x[31:16]};
        u = {1'b0, t[15:0]} + {16'b0, t[16]};
        return u[15:0];
    endfunction

    // Place one payload byte in its half of a 16-bit word.
    function automatic logic [WORD_W-1:0] place_byte(input logic [7:0] b, input logic low_half);
        return low_half ? {8'h00, b} : {b, 8'h00};
    endfunction

endpackage

// File: rtl/csum_beat_sum.sv
module csum_beat_sum
    import csum_pkg::*;
#(
    parameter int DATA_W    = DFLT_DATA_W,
    parameter int KEEP_W    = DATA_W / 8,
    parameter int HDR_BYTES = DFLT_HDR_BYTES,
    parameter int POS_W     = 8,
    parameter int CNT_W     = 6,
    parameter int LSUM_W    = 22
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [KEEP_W-1:0] keep_i,
    input  logic [POS_W-1:0]  pos_i,
    output logic [LSUM_W-1:0] sum_o,
    output logic [CNT_W-1:0]  nkept_o
);

    localparam logic [POS_W-1:0] HDR_P   = POS_W'(HDR_BYTES);
    localparam logic             HDR_ODD = HDR_P[0];

    logic [CNT_W-1:0]  pre      [KEEP_W];
    logic [WORD_W-1:0] lane_val [KEEP_W];

    // Count of kept bytes ahead of each lane inside this beat.
    always_comb begin
        logic [CNT_W-1:0] run;
        run = '0;
        for (int i = 0; i < KEEP_W; i++) begin
            pre[i] = run;
            run    = run + CNT_W'(keep_i[i]);
        end
        nkept_o = run;
    end

    for (genvar g = 0; g < KEEP_W; g++) begin : g_lane
        logic [POS_W-1:0] abs_pos;
        logic             in_body;
        logic             low_half;

        always_comb begin
            abs_pos     = pos_i + POS_W'(pre[g]);
            in_body     = keep_i[g] && (abs_pos >= HDR_P);
            low_half    = abs_pos[0] ^ HDR_ODD;
            lane_val[g] = in_body ? place_byte(data_i[8*g +: 8], low_half) : '0;
        end

        always_comb begin
            if (!keep_i[g]) begin
                assert_masked_lane_R9: assert (lane_val[g] == '0);
            end
            if (keep_i[g] && (pos_i + POS_W'(pre[g])) < HDR_P) begin
                assert_header_lane_R2: assert (lane_val[g] == '0);
            end
        end
    end

    always_comb begin
        logic [LSUM_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < KEEP_W; i++) begin
            acc = acc + LSUM_W'(lane_val[i]);
        end
        sum_o = acc;
    end

endmodule

// File: rtl/csum_pos_track.sv
module csum_pos_track #(
    parameter int HDR_BYTES = 14,
    parameter int POS_W     = 8,
    parameter int CNT_W     = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             beat_i,
    input  logic             last_i,
    input  logic [CNT_W-1:0] nkept_i,
    output logic [POS_W-1:0] pos_o
);

    localparam logic [POS_W-1:0] HDR_P = POS_W'(HDR_BYTES);

    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] advanced;
    logic [POS_W-1:0] past_hdr;
    logic [POS_W-1:0] pos_d;

    // Once past the header only the word parity matters, so the count
    // is pinned to HDR or HDR+1 and never grows with frame length.
    always_comb begin
        advanced = pos_q + POS_W'(nkept_i);
        past_hdr = advanced - HDR_P;
        if (!beat_i) begin
            pos_d = pos_q;
        end else if (last_i) begin
            pos_d = '0;
        end else if (advanced >= HDR_P) begin
            pos_d = HDR_P + POS_W'(past_hdr[0]);
        end else begin
            pos_d = advanced;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    assign pos_o = pos_q;

    assert_pos_bounded_R5: assert property (@(posedge clk) disable iff (rst)
        pos_q <= HDR_P + POS_W'(1));

    assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
        (beat_i && last_i) |=> (pos_q == '0));

    assert_idle_pos_R8: assert property (@(posedge clk) disable iff (rst)
        !beat_i |=> $stable(pos_q));

endmodule

// File: rtl/rx_payload_csum.sv
module rx_payload_csum
    import csum_pkg::*;
#(
    parameter int DATA_W    = DFLT_DATA_W,
    parameter int HDR_BYTES = DFLT_HDR_BYTES
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DATA_W-1:0]   s_data_i,
    input  logic [DATA_W/8-1:0] s_keep_i,
    input  logic                s_valid_i,
    input  logic                s_last_i,
    output logic [15:0]         csum_o,
    output logic                csum_vld_o
);

    localparam int KEEP_W = DATA_W / 8;
    localparam int CNT_W  = $clog2(KEEP_W + 1);
    localparam int POS_W  = $clog2(HDR_BYTES + KEEP_W + 2) + 1;
    localparam int LSUM_W = WORD_W + CNT_W + 1;

    typedef struct packed {
        logic [LSUM_W-1:0] sum;
        logic [CNT_W-1:0]  nkept;
    } beat_res_t;

    typedef struct packed {
        logic [WORD_W-1:0] value;
        logic              vld;
    } result_t;

    beat_res_t         beat;
    logic [POS_W-1:0]  pos;
    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] acc_next;
    result_t           res_q;

    csum_beat_sum #(
        .DATA_W    (DATA_W),
        .KEEP_W    (KEEP_W),
        .HDR_BYTES (HDR_BYTES),
        .POS_W     (POS_W),
        .CNT_W     (CNT_W),
        .LSUM_W    (LSUM_W)
    ) u_beat (
        .data_i  (s_data_i),
        .keep_i  (s_keep_i),
        .pos_i   (pos),
        .sum_o   (beat.sum),
        .nkept_o (beat.nkept)
    );

    csum_pos_track #(
        .HDR_BYTES (HDR_BYTES),
        .POS_W     (POS_W),
        .CNT_W     (CNT_W)
    ) u_pos (
        .clk     (clk),
        .rst     (rst),
        .beat_i  (s_valid_i),
        .last_i  (s_last_i),
        .nkept_i (beat.nkept),
        .pos_o   (pos)
    );

    // Fold every beat into a 16-bit running value so frame length is unbounded.
    always_comb begin
        acc_next = fold32(32'(acc_q) + 32'(beat.sum));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            res_q <= '0;
        end else begin
            res_q.vld <= s_valid_i && s_last_i;
            if (s_valid_i) begin
                if (s_last_i) begin
                    acc_q       <= '0;
                    res_q.value <= acc_next;
                end else begin
                    acc_q <= acc_next;
                end
            end
        end
    end

    assign csum_o     = res_q.value;
    assign csum_vld_o = res_q.vld;

    assert_pulse_after_end_R6: assert property (@(posedge clk) disable iff (rst)
        (s_valid_i && s_last_i) |=> csum_vld_o);

    assert_pulse_has_cause_R6: assert property (@(posedge clk) disable iff (rst)
        csum_vld_o |-> $past(s_valid_i && s_last_i));

    assert_idle_sum_R8: assert property (@(posedge clk) disable iff (rst)
        !s_valid_i |=> $stable(acc_q));

    assert_value_held_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(s_valid_i && s_last_i) |-> $stable(csum_o));

endmodule

// File: tb/sim_rx_payload_csum.sv
module sim_rx_payload_csum;

    localparam int DW = 256;
    localparam int KW = DW / 8;
    localparam int HDR = 14;
    localparam int NT = 10;

    // Table: pattern kind, frame length (bytes incl. header), idle every N beats (0 none), keep holes
    localparam int T_KIND [NT] = '{0, 0, 0, 1, 4, 0, 4, 1, 4, 0};
    localparam int T_LEN  [NT] = '{15, 16, 46, 77, 141, 45, 60, 1514, 9228, 32};
    localparam int T_GAP  [NT] = '{0, 0, 0, 1, 2, 0, 0, 3, 0, 1};
    localparam int T_HOLE [NT] = '{0, 0, 0, 0, 0, 0, 1, 1, 0, 1};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] s_data = '0;
    logic [KW-1:0] s_keep = '0;
    logic          s_valid = 1'b0;
    logic          s_last = 1'b0;
    logic [15:0]   csum;
    logic          csum_vld;

    int checks = 0;
    int errors = 0;
    int got_n = 0;
    int cyc = 0;
    logic [15:0] got [64];

    always #5 clk = ~clk;

    rx_payload_csum u0 (
        .clk        (clk),
        .rst        (rst),
        .s_data_i   (s_data),
        .s_keep_i   (s_keep),
        .s_valid_i  (s_valid),
        .s_last_i   (s_last),
        .csum_o     (csum),
        .csum_vld_o (csum_vld)
    );

    always @(negedge clk) begin
        if (csum_vld) begin
            if (got_n < 64) got[got_n] = csum;
            got_n = got_n + 1;
        end
    end

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc == 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual cycles %0d expected fewer", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [7:0] pat(input int kind, input int idx);
        case (kind)
            0: return 8'(idx);
            1: return ~8'(idx);
            2: return 8'hFF;
            3: begin
                if (idx < HDR) return 8'h5A;
                if (idx == HDR) return 8'hAB;
                if (idx == HDR + 1) return 8'hCD;
                return 8'(idx + 4);
            end
            default: return 8'(idx * 7 + 3);
        endcase
    endfunction

    // Reference sum built straight from the requirement text.
    function automatic logic [15:0] ref_sum(input int kind, input int len);
        longint s = 0;
        for (int i = HDR; i < len; i++) begin
            if (((i - HDR) % 2) == 0) s += longint'(pat(kind, i)) << 8;
            else s += longint'(pat(kind, i));
        end
        while (s > 64'hFFFF) s = (s & 64'hFFFF) + (s >> 16);
        return 16'(s);
    endfunction

    task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_frame(input int kind, input int len, input int gap, input bit holes);
        int idx = 0;
        int beats = 0;
        while (idx < len) begin
            @(negedge clk);
            for (int l = 0; l < KW; l++) begin
                if (holes && (l % 5) == 2) begin
                    s_data[8*l +: 8] = 8'hA5;
                    s_keep[l] = 1'b0;
                end else if (idx < len) begin
                    s_data[8*l +: 8] = pat(kind, idx);
                    s_keep[l] = 1'b1;
                    idx = idx + 1;
                end else begin
                    s_data[8*l +: 8] = 8'h3C;
                    s_keep[l] = 1'b0;
                end
            end
            s_valid = 1'b1;
            s_last = (idx >= len);
            beats = beats + 1;
            if (gap != 0 && (beats % gap) == 0 && idx < len) begin
                @(negedge clk);
                s_valid = 1'b0;
                s_last = 1'b0;
                s_data = {KW{8'hEE}};
                s_keep = '1;
            end
        end
    endtask

    task automatic go_idle(input int n);
        @(negedge clk);
        s_valid = 1'b0;
        s_last = 1'b0;
        s_keep = '0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check16("R1 reset sum", csum, 16'h0000);
        check_int("R1 reset strobe", int'(csum_vld), 0);

        // Table walk
        for (int t = 0; t < NT; t++) begin
            base = got_n;
            send_frame(T_KIND[t], T_LEN[t], T_GAP[t], T_HOLE[t] != 0);
            go_idle(3);
            check_int("R6 one pulse per frame", got_n - base, 1);
            if (t == 3 || t == 9) check16("R8 idle gaps", got[base], ref_sum(T_KIND[t], T_LEN[t]));
            else if (T_HOLE[t] != 0) check16("R9 keep holes", got[base], ref_sum(T_KIND[t], T_LEN[t]));
            else check16("R10 frame sum", got[base], ref_sum(T_KIND[t], T_LEN[t]));
        end

        // Header only
        base = got_n;
        send_frame(0, 14, 0, 0);
        go_idle(3);
        check16("R2 header only", got[base], 16'h0000);

        // Known pairing value
        base = got_n;
        send_frame(3, 104, 0, 0);
        go_idle(3);
        check16("R3 byte pairing", got[base], 16'h8AD8);

        // Odd count: payload 0x0E 0x0F 0x10
        base = got_n;
        send_frame(0, 17, 0, 0);
        go_idle(3);
        check16("R4 odd tail", got[base], 16'h1E0F);

        // Long all-ones frame
        base = got_n;
        send_frame(2, 10240, 0, 0);
        go_idle(3);
        check16("R5 all ones fold", got[base], 16'hFFFF);

        // Back-to-back frames
        base = got_n;
        send_frame(0, 50, 0, 0);
        send_frame(1, 50, 0, 0);
        send_frame(4, 33, 0, 1);
        go_idle(3);
        check_int("R7 pulse count", got_n - base, 3);
        check16("R7 first", got[base], ref_sum(0, 50));
        check16("R7 second", got[base + 1], ref_sum(1, 50));
        check16("R7 third", got[base + 2], ref_sum(4, 33));
        check_int("R6 strobe low when idle", int'(csum_vld), 0);

        // Reset mid-frame
        @(negedge clk);
        s_data = {KW{8'h77}};
        s_keep = '1;
        s_valid = 1'b1;
        s_last = 1'b0;
        @(negedge clk);
        s_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_int("R1 strobe after reset", int'(csum_vld), 0);
        check16("R1 value after reset", csum, 16'h0000);
        base = got_n;
        send_frame(4, 40, 0, 0);
        go_idle(3);
        check16("R1 clean restart", got[base], ref_sum(4, 40));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule